// File: doc/BRIEF.md
# System Mode Control Register Block

This block is a pair of memory-mapped registers for a microcontroller-class system. The control register gates entry into the core's two low-power modes, stop and wait. Each mode is governed by a two-bit field: one code lets the mode be entered, one code blocks it, and two codes block it and lock the field until the next reset. The same register also holds a self-clearing software reset trigger, a bit that forces the debug clock on, and a read-only view of the live boot-mode pin.

The status register records which kinds of reset have occurred since power-on. A power-on, external, watchdog or software reset each sets its own sticky flag and leaves the other flags alone. Power-on reset rewrites the whole register. Apart from that, only software can clear a flag, by writing a one to it.

During any reset the block samples the boot-mode pin together with the boot strap input. The result drives the select that decides whether the upper address lines start as address or as GPIO.

The bus is synchronous. Writes take effect on the clock edge where `bus_we` is high, and reads are combinational from `bus_addr`. All resets are synchronous and active high. `ext_rst`, `wdog_rst` and a software reset are device resets, which clear the control register. `por` clears both registers.

Top module: `sysmode_ctl`

## Requirements
- R1: Power-on reset gives these values one edge later: control register all zeros except bit 6, status register 0x0004 (only bit 2 set), `sw_rst_pulse` 0 and `dbg_clk_en` equal to `tap_en`.
- R2: The wait mode field (control bits 1:0) and the stop mode field (bits 3:2) are independent. A grant output is high exactly when its request is high and its field holds 00.
- R3: A field holding 00 or 01 takes any written value, including 10 and 11. Code 01 blocks its grant.
- R4: Codes 10 and 11 block the grant. Every later write to that field is ignored until a device reset or power-on reset.
- R5: Writing 1 to control bit 4 starts a software reset, and bit 4 always reads 0. `sw_rst_pulse` is high for the single cycle after the writing edge. The other bits of that write are ignored, and the control register returns to its reset value, which releases any lock.
- R6: Control bit 5 set to 1 forces `dbg_clk_en` high. Set to 0, `dbg_clk_en` follows `tap_en`.
- R7: Control bit 6 reads the present level of `boot_pin` with no clock delay. Writes to it have no effect.
- R8: `hi_addr_sel` takes `boot_pin & boot_strap` on every edge where any reset is active (power-on, external, watchdog or software) and holds its value at all other edges.
- R9: Status flags sit at bit 2 (power-on), bit 3 (external), bit 4 (watchdog) and bit 5 (software). Each reset event sets only its own flag and never clears another.
- R10: A status write clears each flag whose data bit is 1 and leaves flags whose data bit is 0. A reset event in the same cycle wins, leaving its flag set. Status bits other than 5:2 read 0.
- R11: The control register sits at address 0 and the status register at address 1. Other addresses read 0, and writes to them change no state and start no software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | External reset event, synchronous, active high |
| wdog_rst | input | 1 | Watchdog reset event, synchronous, active high |
| boot_pin | input | 1 | Boot-mode pin level |
| boot_strap | input | 1 | External boot strap level |
| tap_en | input | 1 | Debug TAP enabled |
| stop_req | input | 1 | Core requests stop mode |
| wait_req | input | 1 | Core requests wait mode |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| stop_grant | output | 1 | Stop mode entry allowed |
| wait_grant | output | 1 | Wait mode entry allowed |
| sw_rst_pulse | output | 1 | One-cycle software reset request |
| dbg_clk_en | output | 1 | Debug clock enable |
| hi_addr_sel | output | 1 | 1 = upper address lines start as address, 0 = as GPIO |

## Verification
The hardest situations to reach from the ports are a status-clear write that lands in the same cycle as a reset event, and a field that is locked and must stay locked until exactly the next reset. The bench drives the status write and the external reset pulse in one cycle, then reads the flag back. For every pair of first and second field codes it reaches the state through a fresh external reset, which proves lock, release and independence on both fields. It then releases a lock through a software reset and writes the field again.

// File: rtl/sysmode_pkg.sv
package sysmode_pkg;

   // Control register bit map
   localparam int WAIT_LSB  = 0;
   localparam int STOP_LSB  = 2;
   localparam int SWR_BIT   = 4;
   localparam int DBG_BIT   = 5;
   localparam int PIN_BIT   = 6;
   localparam int LPM_W     = 2;
   localparam int NUM_LPM   = 2;   // index 0 wait, 1 stop

   // Status register bit map
   localparam int CAUSE_LSB = 2;
   localparam int NUM_CAUSE = 4;   // 0 por, 1 ext, 2 wdog, 3 sw
   localparam int CAUSE_POR = 0;
   localparam int CAUSE_EXT = 1;
   localparam int CAUSE_WDG = 2;
   localparam int CAUSE_SWR = 3;

   typedef enum logic [LPM_W-1:0] {
      LPM_ALLOW = 2'b00,
      LPM_BLOCK = 2'b01,
      LPM_LOCK  = 2'b10,
      LPM_LOCK2 = 2'b11
   } lpm_code_e;

   function automatic logic lpm_locked(input logic [LPM_W-1:0] code);
      return code[LPM_W-1];
   endfunction

endpackage

// File: rtl/sysmode_lpm_field.sv
module sysmode_lpm_field
   import sysmode_pkg::*;
(
   input  logic             clk,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [LPM_W-1:0] wr_code,
   input  logic             req,
   output logic [LPM_W-1:0] code_q,
   output logic             grant
);

   always_ff @(posedge clk) begin
      if (clr)
         code_q <= LPM_ALLOW;
      else if (wr_en && !lpm_locked(code_q))
         code_q <= wr_code;
   end

   assign grant = req && (code_q == LPM_ALLOW);

endmodule

// File: rtl/sysmode_rst_cause.sv
module sysmode_rst_cause #(
   parameter int NUM_CAUSE = 4
) (
   input  logic                 clk,
   input  logic                 por,
   input  logic [NUM_CAUSE-1:0] evt,
   input  logic                 clr_en,
   input  logic [NUM_CAUSE-1:0] clr_mask,
   output logic [NUM_CAUSE-1:0] flags_q
);

   if (NUM_CAUSE < 1) begin : g_bad_n
      $error("sysmode_rst_cause: NUM_CAUSE must be at least 1");
   end

   // Cause 0 is the power-on flag; evt[0] is not used.
   logic unused_evt0;
   assign unused_evt0 = evt[0];

   for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_flag
      logic bit_q;
      if (i == 0) begin : g_por
         always_ff @(posedge clk) begin
            if (por)
               bit_q <= 1'b1;
            else if (clr_en && clr_mask[i])
               bit_q <= 1'b0;
         end
      end else begin : g_evt
         always_ff @(posedge clk) begin
            if (por)
               bit_q <= 1'b0;
            else if (evt[i])
               bit_q <= 1'b1;
            else if (clr_en && clr_mask[i])
               bit_q <= 1'b0;
         end
      end
      assign flags_q[i] = bit_q;
   end

endmodule

// File: rtl/sysmode_boot_sel.sv
module sysmode_boot_sel (
   input  logic clk,
   input  logic sample,
   input  logic boot_pin,
   input  logic boot_strap,
   output logic sel_q
);

   always_ff @(posedge clk) begin
      if (sample)
         sel_q <= boot_pin & boot_strap;
   end

endmodule

// File: rtl/sysmode_ctl.sv
module sysmode_ctl
   import sysmode_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4,
   parameter int CTL_ADDR = 0,
   parameter int STS_ADDR = 1
) (
   input  logic              clk,
   input  logic              por,
   input  logic              ext_rst,
   input  logic              wdog_rst,
   input  logic              boot_pin,
   input  logic              boot_strap,
   input  logic              tap_en,
   input  logic              stop_req,
   input  logic              wait_req,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              stop_grant,
   output logic              wait_grant,
   output logic              sw_rst_pulse,
   output logic              dbg_clk_en,
   output logic              hi_addr_sel
);

   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);
   localparam int MODE_W = NUM_LPM * LPM_W;

   // Elaboration-time parameter checks
   if (DATA_W <= PIN_BIT) begin : g_bad_width
      $error("sysmode_ctl: DATA_W must exceed the highest control bit");
   end
   if (CAUSE_LSB + NUM_CAUSE > DATA_W) begin : g_bad_cause
      $error("sysmode_ctl: status flags do not fit in DATA_W");
   end
   if (CTL_ADDR == STS_ADDR) begin : g_bad_addr
      $error("sysmode_ctl: register addresses must differ");
   end
   if (CTL_ADDR >= (1 << ADDR_W) || STS_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("sysmode_ctl: register address out of range");
   end

   // Bus decode
   logic sel_ctl, sel_sts, ctl_wr, sts_wr, swr_evt, dev_rst, any_rst;
   assign sel_ctl = (bus_addr == CTL_A);
   assign sel_sts = (bus_addr == STS_A);
   assign ctl_wr  = bus_we && sel_ctl;
   assign sts_wr  = bus_we && sel_sts;
   assign swr_evt = ctl_wr && bus_wdata[SWR_BIT];
   assign dev_rst = ext_rst || wdog_rst || swr_evt;
   assign any_rst = por || dev_rst;

   // Low-power mode fields
   logic [NUM_LPM-1:0] lpm_req, lpm_gnt;
   logic [MODE_W-1:0]  mode_q;
   assign lpm_req = {stop_req, wait_req};

   for (genvar g = 0; g < NUM_LPM; g++) begin : g_lpm
      localparam int LSB = WAIT_LSB + LPM_W * g;
      sysmode_lpm_field i_fld (
         .clk     (clk),
         .clr     (any_rst),
         .wr_en   (ctl_wr),
         .wr_code (bus_wdata[LSB +: LPM_W]),
         .req     (lpm_req[g]),
         .code_q  (mode_q[LSB +: LPM_W]),
         .grant   (lpm_gnt[g])
      );
   end

   assign {stop_grant, wait_grant} = lpm_gnt;

   // Debug clock force bit
   logic dbg_q;
   always_ff @(posedge clk) begin
      if (any_rst)
         dbg_q <= 1'b0;
      else if (ctl_wr)
         dbg_q <= bus_wdata[DBG_BIT];
   end
   assign dbg_clk_en = dbg_q || tap_en;

   // Software reset pulse
   logic swr_q;
   always_ff @(posedge clk) begin
      if (por)
         swr_q <= 1'b0;
      else
         swr_q <= swr_evt;
   end
   assign sw_rst_pulse = swr_q;

   // Reset cause flags
   logic [NUM_CAUSE-1:0] cause_evt, flags_q;
   always_comb begin
      cause_evt            = '0;
      cause_evt[CAUSE_EXT] = ext_rst;
      cause_evt[CAUSE_WDG] = wdog_rst;
      cause_evt[CAUSE_SWR] = swr_evt;
   end

   sysmode_rst_cause #(.NUM_CAUSE(NUM_CAUSE)) i_cause (
      .clk      (clk),
      .por      (por),
      .evt      (cause_evt),
      .clr_en   (sts_wr),
      .clr_mask (bus_wdata[CAUSE_LSB +: NUM_CAUSE]),
      .flags_q  (flags_q)
   );

   // Boot address select
   sysmode_boot_sel i_boot (
      .clk        (clk),
      .sample     (any_rst),
      .boot_pin   (boot_pin),
      .boot_strap (boot_strap),
      .sel_q      (hi_addr_sel)
   );

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (sel_ctl) begin
         bus_rdata[MODE_W-1:0] = mode_q;
         bus_rdata[DBG_BIT]    = dbg_q;
         bus_rdata[PIN_BIT]    = boot_pin;
      end else if (sel_sts) begin
         bus_rdata[CAUSE_LSB +: NUM_CAUSE] = flags_q;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata[DATA_W-1:PIN_BIT];

endmodule

// File: rtl/sysmode_ctl_chk.sv
module sysmode_ctl_chk
   import sysmode_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4,
   parameter int CTL_ADDR = 0,
   parameter int STS_ADDR = 1
) (
   input logic              clk,
   input logic              por,
   input logic              tap_en,
   input logic              stop_req,
   input logic              wait_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              stop_grant,
   input logic              wait_grant,
   input logic              sw_rst_pulse,
   input logic              dbg_clk_en,
   input logic              hi_addr_sel,
   input logic [3:0]        mode_q,
   input logic [3:0]        flags_q,
   input logic              dev_rst
);

   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);

   a_r2_stop_needs_req: assert property (@(posedge clk) disable iff (por)
      stop_grant |-> stop_req);
   a_r2_wait_needs_req: assert property (@(posedge clk) disable iff (por)
      wait_grant |-> wait_req);
   a_r4_stop_locked_no_grant: assert property (@(posedge clk) disable iff (por)
      mode_q[3] |-> !stop_grant);
   a_r4_stop_lock_holds: assert property (@(posedge clk) disable iff (por)
      (!$past(por) && !$past(dev_rst) && $past(mode_q[3]))
         |-> (mode_q[3:2] == $past(mode_q[3:2])));
   a_r4_wait_lock_holds: assert property (@(posedge clk) disable iff (por)
      (!$past(por) && !$past(dev_rst) && $past(mode_q[1]))
         |-> (mode_q[1:0] == $past(mode_q[1:0])));
   a_r5_pulse_from_write: assert property (@(posedge clk) disable iff (por)
      sw_rst_pulse |-> $past(bus_we && bus_addr == CTL_A && bus_wdata[SWR_BIT]));
   a_r5_pulse_clears_modes: assert property (@(posedge clk) disable iff (por)
      sw_rst_pulse |-> (mode_q == 4'b0000));
   a_r6_tap_enables_clock: assert property (@(posedge clk) disable iff (por)
      tap_en |-> dbg_clk_en);
   a_r8_boot_sel_holds: assert property (@(posedge clk) disable iff (por)
      (!$past(por) && !$past(dev_rst)) |-> $stable(hi_addr_sel));
   a_r1_por_status: assert property (@(posedge clk) disable iff (por)
      $fell(por) |-> (flags_q == 4'b0001));

   for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_sticky
      a_r9_flag_sticky: assert property (@(posedge clk) disable iff (por)
         (!$past(por) && $past(flags_q[i]) &&
          !$past(bus_we && bus_addr == STS_A && bus_wdata[CAUSE_LSB + i]))
            |-> flags_q[i]);
   end

endmodule

bind sysmode_ctl sysmode_ctl_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .CTL_ADDR (CTL_ADDR),
   .STS_ADDR (STS_ADDR)
) i_chk (
   .clk          (clk),
   .por          (por),
   .tap_en       (tap_en),
   .stop_req     (stop_req),
   .wait_req     (wait_req),
   .bus_addr     (bus_addr),
   .bus_we       (bus_we),
   .bus_wdata    (bus_wdata),
   .stop_grant   (stop_grant),
   .wait_grant   (wait_grant),
   .sw_rst_pulse (sw_rst_pulse),
   .dbg_clk_en   (dbg_clk_en),
   .hi_addr_sel  (hi_addr_sel),
   .mode_q       (mode_q),
   .flags_q      (flags_q),
   .dev_rst      (dev_rst)
);

// File: tb/test_sysmode_ctl.sv
module test_sysmode_ctl;

   localparam int CTL = 0;
   localparam int STS = 1;

   logic        clk = 1'b0;
   logic        por, ext_rst, wdog_rst, boot_pin, boot_strap, tap_en;
   logic        stop_req, wait_req, we;
   logic [3:0]  addr;
   logic [15:0] wdata, rdata;
   logic        stop_grant, wait_grant, sw_rst_pulse, dbg_clk_en, hi_addr_sel;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   sysmode_ctl i_sysmode_ctl (
      .clk(clk), .por(por), .ext_rst(ext_rst), .wdog_rst(wdog_rst),
      .boot_pin(boot_pin), .boot_strap(boot_strap), .tap_en(tap_en),
      .stop_req(stop_req), .wait_req(wait_req),
      .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
      .stop_grant(stop_grant), .wait_grant(wait_grant),
      .sw_rst_pulse(sw_rst_pulse), .dbg_clk_en(dbg_clk_en),
      .hi_addr_sel(hi_addr_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      addr = 4'(a);
      #1;
      v = rdata;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      addr = 4'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic pulse_ext();
      @(negedge clk); ext_rst = 1'b1;
      @(negedge clk); ext_rst = 1'b0;
   endtask

   task automatic pulse_wdog();
      @(negedge clk); wdog_rst = 1'b1;
      @(negedge clk); wdog_rst = 1'b0;
   endtask

   task automatic do_por();
      @(negedge clk); por = 1'b1;
      repeat (2) @(negedge clk);
      por = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] v, c0, s0;
      por = 1'b1; ext_rst = 0; wdog_rst = 0; boot_pin = 1; boot_strap = 1;
      tap_en = 0; stop_req = 0; wait_req = 0; we = 0; addr = 0; wdata = 0;
      repeat (3) @(negedge clk);
      por = 1'b0;

      // R1 reset state
      rd(STS, v); chk("R1 status after por", v, 16'h0004);
      rd(CTL, v); chk("R1 control after por", v, 16'h0040);
      chk("R1 sw pulse low", sw_rst_pulse, 0);
      chk("R1 debug clock off", dbg_clk_en, 0);
      chk("R8 boot select after por", hi_addr_sel, 1);

      // R7 live pin reflection, R8 hold
      boot_pin = 0; rd(CTL, v); chk("R7 pin low seen", v, 16'h0000);
      chk("R8 select held on pin change", hi_addr_sel, 1);
      wr(CTL, 16'h0040); rd(CTL, v); chk("R7 pin bit not writable", v, 16'h0000);
      boot_pin = 1; rd(CTL, v); chk("R7 pin high seen", v, 16'h0040);

      // R2 grants follow requests
      stop_req = 0; wait_req = 0; #1;
      chk("R2 no request no grant", {stop_grant, wait_grant}, 0);

      // R2/R3/R4 field sweep over both fields
      for (int f = 0; f < 2; f++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
               int e;
               pulse_ext();
               wr(CTL, 16'(a << (2 * f)));
               wr(CTL, 16'(b << (2 * f)));
               e = (a >= 2) ? a : b;
               rd(CTL, v);
               chk((a >= 2) ? "R4 locked field ignores write" : "R3 open field takes write",
                   v & 16'h000F, 32'(e << (2 * f)));
               stop_req = 1; wait_req = 1; #1;
               chk("R2 grant for field", f ? stop_grant : wait_grant, (e == 0));
               chk("R2 other field independent", f ? wait_grant : stop_grant, 1);
               stop_req = 0; wait_req = 0;
            end

      // R5 software reset releases lock and clears control
      pulse_ext();
      wr(CTL, 16'h002A);
      rd(CTL, v); chk("R4 both locked and debug set", v & 16'h003F, 16'h002A);
      @(negedge clk); addr = CTL; wdata = 16'h0011; we = 1;
      @(negedge clk); we = 0; wdata = 0;
      chk("R5 pulse high one cycle after write", sw_rst_pulse, 1);
      rd(CTL, v); chk("R5 control cleared, bit4 reads 0", v & 16'h003F, 16'h0000);
      @(negedge clk);
      chk("R5 pulse only one cycle", sw_rst_pulse, 0);
      wr(CTL, 16'h0004); rd(CTL, v); chk("R5 lock released", v & 16'h000F, 16'h0004);
      wr(CTL, 16'h0015); rd(CTL, v); chk("R5 other write bits ignored", v & 16'h003F, 16'h0000);
      rd(STS, v); chk("R9 software flag set", v[5], 1);

      // R6 debug clock
      for (int d = 0; d < 2; d++)
         for (int t = 0; t < 2; t++) begin
            wr(CTL, 16'(d << 5)); tap_en = t[0]; #1;
            chk("R6 debug clock enable", dbg_clk_en, d | t);
         end
      tap_en = 0;

      // R8 boot select sampled in resets
      for (int p = 0; p < 2; p++)
         for (int s = 0; s < 2; s++) begin
            boot_pin = p[0]; boot_strap = s[0];
            pulse_wdog();
            chk("R8 select sampled in reset", hi_addr_sel, p & s);
            boot_pin = ~boot_pin; boot_strap = ~boot_strap;
            wr(CTL, 16'h0000);
            chk("R8 select held outside reset", hi_addr_sel, p & s);
         end
      boot_pin = 1; boot_strap = 1;
      wr(CTL, 16'h0010);
      chk("R8 select sampled in software reset", hi_addr_sel, 1);

      // R9 sticky flags
      do_por();
      rd(STS, v); chk("R1 por only flag", v, 16'h0004);
      pulse_ext();  rd(STS, v); chk("R9 external flag added", v, 16'h000C);
      pulse_wdog(); rd(STS, v); chk("R9 watchdog flag added", v, 16'h001C);
      wr(CTL, 16'h0010); rd(STS, v); chk("R9 software flag added", v, 16'h003C);
      do_por();
      rd(STS, v); chk("R1 por reinitialises status", v, 16'h0004);

      // R10 write-one-to-clear sweep
      for (int m = 0; m < 16; m++) begin
         do_por(); pulse_ext(); pulse_wdog(); wr(CTL, 16'h0010);
         wr(STS, 16'(m << 2) | 16'hFFC3);
         rd(STS, v);
         chk("R10 clear by mask", v, 16'h003C & ~16'(m << 2));
      end

      // R10 reset event wins over clear in same cycle
      pulse_ext();
      @(negedge clk); addr = STS; wdata = 16'h0008; we = 1; ext_rst = 1;
      @(negedge clk); we = 0; ext_rst = 0; wdata = 0;
      rd(STS, v); chk("R10 reset beats clear", v[3], 1);

      // R11 unmapped address
      wr(CTL, 16'h0009);
      rd(CTL, c0); rd(STS, s0);
      wr(7, 16'hFFFF);
      chk("R11 no software reset from unmapped write", sw_rst_pulse, 0);
      rd(CTL, v); chk("R11 control unchanged", v, c0);
      rd(STS, v); chk("R11 status unchanged", v, s0);
      rd(7, v); chk("R11 unmapped reads zero", v, 16'h0000);

      summary();
      $finish;
   end

endmodule